// File: doc/BRIEF.md
# Fused-Operation Integer ALU

This unit is a purely combinational 64-bit integer execution datapath. It carries out the merged operations that a front end produces when it folds two neighbouring integer instructions into one internal operation. Each operation gives, bit for bit, the value that the original two-step sequence would have left in its destination register. This includes the 32-bit wrap and the sign extension of word-width arithmetic, and the masking done by narrowing steps.

The unit takes two 64-bit source operands and a 5-bit operation code, and returns a 64-bit result in the same cycle. Three sub-units run side by side:

- an extend/shift unit, which reads only the first operand;
- an adder unit, for shift-then-add, odd-add and word-add-then-narrow;
- a logic unit, for masked-OR and logic-then-narrow.

Only the sub-unit that owns the current code drives a non-zero value. The top level ORs the three outputs together. Codes with no assigned operation give zero and raise a flag.

Top module: `fz_alu`

## Requirements
- R1: Code 0 returns the low 32 bits of `src1_i`, zero-extended. Code 1 returns `src1_i[15:0]`, zero-extended. Code 2 returns `src1_i[15:0]`, sign-extended from bit 15. `src2_i` has no effect on any of the three.
- R2: Codes 3, 4 and 5 return the zero-extended low word of `src1_i` shifted left by 1, 2 and 3 respectively. This equals a left shift by 32 followed by a logical right shift by 31, 30 or 29.
- R3: Code 6 returns `src1_i[15:8]`, zero-extended to 64 bits.
- R4: Code 7 returns `(src1_i << 4) + src2_i`, modulo 2^64.
- R5: Codes 8, 9, 10 and 11 return `(src1_i >> N) + src2_i` modulo 2^64, with a logical shift and N equal to 29, 30, 31 and 32 respectively.
- R6: Code 12 returns `src2_i + src1_i[0]` in 64 bits. Code 13 forms the same sum in 32 bits and sign-extends its bit 31.
- R7: Code 14 returns `{src1_i[63:8], 8'h00} | src2_i`.
- R8: Codes 15 to 18 first form the 32-bit sum of the operands' low words. They then return, respectively: bits [7:0] zero-extended; bit 0 alone; bits [15:0] zero-extended; bits [15:0] sign-extended.
- R9: Codes 19, 20 and 21 return bit 0 of AND, OR and XOR of the operands. Codes 23, 24 and 25 return bits [15:0] of the same three, zero-extended.
- R10: Codes 22 and 26 apply the OR-combine-bytes operation to `src1_i` and then return bit 0 (code 22) or bits [15:0] zero-extended (code 26). In OR-combine-bytes, each result byte is 0xFF if any bit of the matching source byte is set, and 0x00 otherwise.
- R11: Codes 27 to 31 give a zero result with `illegal_o` high. Every code from 0 to 26 keeps `illegal_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand |
| op_i | input | 5 | Operation code, values listed in the requirements |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | High when `op_i` names no operation |

## Verification
The unit is combinational, so no two operations share a cycle. The behaviours that do meet in one evaluation are the word-width wrap and the narrowing or sign-extension that follows it. An example is a 32-bit sum that overflows into bit 31 and then feeds the sign-extend of its low half. The bench provokes this by crossing the corner operands 0, all-ones, 0x7FFFFFFF and 0x80000000 against one another for every code. It judges each result against a model written as the literal two-step instruction sequence.

// File: rtl/fz_alu_pkg.sv
// Package: operation codes and shared widths for the fused-operation ALU.
// Assumes a 64-bit datapath with 32-bit words; code values are fixed by
// the decoder that feeds this unit.
package fz_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ZEXT_W    = 5'd0,
        OP_ZEXT_H    = 5'd1,
        OP_SEXT_H    = 5'd2,
        OP_SZW_SL1   = 5'd3,
        OP_SZW_SL2   = 5'd4,
        OP_SZW_SL3   = 5'd5,
        OP_BYTE1     = 5'd6,
        OP_SL4_ADD   = 5'd7,
        OP_SR29_ADD  = 5'd8,
        OP_SR30_ADD  = 5'd9,
        OP_SR31_ADD  = 5'd10,
        OP_SR32_ADD  = 5'd11,
        OP_ODD_ADD   = 5'd12,
        OP_ODD_ADDW  = 5'd13,
        OP_MASK_OR   = 5'd14,
        OP_WADD_B8   = 5'd15,
        OP_WADD_B1   = 5'd16,
        OP_WADD_ZH   = 5'd17,
        OP_WADD_SH   = 5'd18,
        OP_AND_B1    = 5'd19,
        OP_OR_B1     = 5'd20,
        OP_XOR_B1    = 5'd21,
        OP_ORCB_B1   = 5'd22,
        OP_AND_ZH    = 5'd23,
        OP_OR_ZH     = 5'd24,
        OP_XOR_ZH    = 5'd25,
        OP_ORCB_ZH   = 5'd26
    } fz_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 5'd26;

    // Kind of bitwise combine used by the logic-then-narrow group.
    typedef enum logic [1:0] {
        LK_AND  = 2'd0,
        LK_OR   = 2'd1,
        LK_XOR  = 2'd2,
        LK_ORCB = 2'd3
    } fz_lkind_e;

endpackage

// File: rtl/fz_ext_shift.sv
// Module: extend / shift / extract unit.
// Handles the operations that read only src1 (codes 0..6) and gives zero
// for any other code. Assumes XLEN is 64 so that word and half widths follow.
module fz_ext_shift
    import fz_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src1_i,
    input  fz_op_e          op_i,
    output logic [XLEN-1:0] res_o
);
    localparam int WLEN = XLEN / 2;
    localparam int HLEN = XLEN / 4;
    localparam int BLEN = 8;

    logic [XLEN-1:0] zw;
    logic [XLEN-1:0] zh;
    logic [XLEN-1:0] sh;
    logic [XLEN-1:0] b1;

    // Purpose: build the word/half/byte extensions of src1 shared by the ops.
    always_comb begin
        zw = {{(XLEN-WLEN){1'b0}}, src1_i[WLEN-1:0]};
        zh = {{(XLEN-HLEN){1'b0}}, src1_i[HLEN-1:0]};
        sh = {{(XLEN-HLEN){src1_i[HLEN-1]}}, src1_i[HLEN-1:0]};
        b1 = {{(XLEN-BLEN){1'b0}}, src1_i[2*BLEN-1:BLEN]};
    end

    // Purpose: pick the result for this unit's codes, zero elsewhere.
    always_comb begin
        res_o = '0;
        case (op_i)
            OP_ZEXT_W:  res_o = zw;
            OP_ZEXT_H:  res_o = zh;
            OP_SEXT_H:  res_o = sh;
            OP_SZW_SL1: res_o = zw << 1;
            OP_SZW_SL2: res_o = zw << 2;
            OP_SZW_SL3: res_o = zw << 3;
            OP_BYTE1:   res_o = b1;
            default:    res_o = '0;
        endcase
    end
endmodule

// File: rtl/fz_adder_unit.sv
// Module: adder unit.
// Covers shift-then-add, odd-add and word-add-then-narrow (codes 7..13,
// 15..18) and gives zero for any other code. Every sum wraps at its width.
module fz_adder_unit
    import fz_alu_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int SR_BASE   = 29,
    parameter int SR_COUNT  = 4
) (
    input  logic [XLEN-1:0] src1_i,
    input  logic [XLEN-1:0] src2_i,
    input  fz_op_e          op_i,
    output logic [XLEN-1:0] res_o
);
    localparam int WLEN = XLEN / 2;
    localparam int HLEN = XLEN / 4;
    localparam int BLEN = 8;

    logic [XLEN-1:0] sr_sum [SR_COUNT];
    logic [XLEN-1:0] sl4_sum;
    logic [XLEN-1:0] odd_sum;
    logic [WLEN-1:0] odd_wsum;
    logic [WLEN-1:0] wsum;

    // One adder per right-shift distance of the shift-then-add group.
    for (genvar g = 0; g < SR_COUNT; g++) begin : g_sradd
        assign sr_sum[g] = (src1_i >> (SR_BASE + g)) + src2_i;
    end

    // Purpose: the remaining adders of the group.
    always_comb begin
        sl4_sum  = (src1_i << 4) + src2_i;
        odd_sum  = src2_i + {{(XLEN-1){1'b0}}, src1_i[0]};
        odd_wsum = src2_i[WLEN-1:0] + {{(WLEN-1){1'b0}}, src1_i[0]};
        wsum     = src1_i[WLEN-1:0] + src2_i[WLEN-1:0];
    end

    // Purpose: pick and narrow the result for this unit's codes.
    always_comb begin
        res_o = '0;
        case (op_i)
            OP_SL4_ADD:  res_o = sl4_sum;
            OP_SR29_ADD: res_o = sr_sum[0];
            OP_SR30_ADD: res_o = sr_sum[1];
            OP_SR31_ADD: res_o = sr_sum[2];
            OP_SR32_ADD: res_o = sr_sum[3];
            OP_ODD_ADD:  res_o = odd_sum;
            OP_ODD_ADDW: res_o = {{(XLEN-WLEN){odd_wsum[WLEN-1]}}, odd_wsum};
            OP_WADD_B8:  res_o = {{(XLEN-BLEN){1'b0}}, wsum[BLEN-1:0]};
            OP_WADD_B1:  res_o = {{(XLEN-1){1'b0}}, wsum[0]};
            OP_WADD_ZH:  res_o = {{(XLEN-HLEN){1'b0}}, wsum[HLEN-1:0]};
            OP_WADD_SH:  res_o = {{(XLEN-HLEN){wsum[HLEN-1]}}, wsum[HLEN-1:0]};
            default:     res_o = '0;
        endcase
    end
endmodule

// File: rtl/fz_logic_unit.sv
// Module: logic unit.
// Covers masked-OR and logic-then-narrow (codes 14, 19..26) and gives zero
// for any other code. Assumes XLEN is a whole number of bytes.
module fz_logic_unit
    import fz_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src1_i,
    input  logic [XLEN-1:0] src2_i,
    input  fz_op_e          op_i,
    output logic [XLEN-1:0] res_o
);
    localparam int BLEN   = 8;
    localparam int NBYTES = XLEN / BLEN;
    localparam int HLEN   = XLEN / 4;

    logic [XLEN-1:0] orcb;
    logic [XLEN-1:0] comb;
    fz_lkind_e       kind;
    logic            narrow_bit;
    logic            is_narrow;

    // Each byte of the OR-combine becomes all ones if any source bit is set.
    for (genvar b = 0; b < NBYTES; b++) begin : g_orcb
        assign orcb[b*BLEN +: BLEN] = {BLEN{|src1_i[b*BLEN +: BLEN]}};
    end

    // Purpose: decode the combine kind and the narrowing width from the code.
    always_comb begin
        kind       = LK_AND;
        narrow_bit = 1'b0;
        is_narrow  = 1'b1;
        case (op_i)
            OP_AND_B1:  begin kind = LK_AND;  narrow_bit = 1'b1; end
            OP_OR_B1:   begin kind = LK_OR;   narrow_bit = 1'b1; end
            OP_XOR_B1:  begin kind = LK_XOR;  narrow_bit = 1'b1; end
            OP_ORCB_B1: begin kind = LK_ORCB; narrow_bit = 1'b1; end
            OP_AND_ZH:  kind = LK_AND;
            OP_OR_ZH:   kind = LK_OR;
            OP_XOR_ZH:  kind = LK_XOR;
            OP_ORCB_ZH: kind = LK_ORCB;
            default:    is_narrow = 1'b0;
        endcase
    end

    // Purpose: form the bitwise combine selected by the decoded kind.
    always_comb begin
        case (kind)
            LK_AND:  comb = src1_i & src2_i;
            LK_OR:   comb = src1_i | src2_i;
            LK_XOR:  comb = src1_i ^ src2_i;
            default: comb = orcb;
        endcase
    end

    // Purpose: narrow the combine, or form the masked OR, for this unit's codes.
    always_comb begin
        res_o = '0;
        if (op_i == OP_MASK_OR) begin
            res_o = {src1_i[XLEN-1:BLEN], {BLEN{1'b0}}} | src2_i;
        end else if (is_narrow && narrow_bit) begin
            res_o = {{(XLEN-1){1'b0}}, comb[0]};
        end else if (is_narrow) begin
            res_o = {{(XLEN-HLEN){1'b0}}, comb[HLEN-1:0]};
        end
    end
endmodule

// File: rtl/fz_alu.sv
// Module: fused-operation ALU top.
// Purely combinational. The three sub-units run in parallel and each gives
// zero outside its own codes, so their outputs are merged with an OR. Codes
// above the last assigned one raise illegal_o and give a zero result.
module fz_alu
    import fz_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src1_i,
    input  logic [XLEN-1:0] src2_i,
    input  logic [OP_W-1:0] op_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o
);
    fz_op_e          op;
    logic [XLEN-1:0] es_res;
    logic [XLEN-1:0] ad_res;
    logic [XLEN-1:0] lg_res;

    assign op = fz_op_e'(op_i);

    fz_ext_shift #(.XLEN(XLEN)) u_ext_shift (
        .src1_i (src1_i),
        .op_i   (op),
        .res_o  (es_res)
    );

    fz_adder_unit #(.XLEN(XLEN)) u_adder (
        .src1_i (src1_i),
        .src2_i (src2_i),
        .op_i   (op),
        .res_o  (ad_res)
    );

    fz_logic_unit #(.XLEN(XLEN)) u_logic (
        .src1_i (src1_i),
        .src2_i (src2_i),
        .op_i   (op),
        .res_o  (lg_res)
    );

    // Purpose: flag unassigned codes and merge the sub-unit results.
    always_comb begin
        illegal_o = (op_i > OP_LAST);
        result_o  = es_res | ad_res | lg_res;
    end
endmodule

// File: rtl/fz_alu_chk.sv
// Module: assertion checker for fz_alu, attached by bind.
// The unit has no clock, so the checks are immediate and are evaluated
// whenever the ports change. They are skipped while any input is unknown.
module fz_alu_chk
    import fz_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic [XLEN-1:0] src1_i,
    input logic [XLEN-1:0] src2_i,
    input logic [OP_W-1:0] op_i,
    input logic [XLEN-1:0] result_o,
    input logic            illegal_o
);
    // Purpose: check result shapes per code group against the ports.
    always_comb begin
        if (!$isunknown({src1_i, src2_i, op_i})) begin
            AST_ILLEGAL_ZERO: assert (!illegal_o || result_o == '0);          // R11
            AST_LEGAL_NOFLAG: assert (op_i > OP_LAST || !illegal_o);          // R11
            AST_SEXT_HALF: assert (!(op_i == 5'd2 || op_i == 5'd18) ||
                result_o[XLEN-1:15] == '0 || &result_o[XLEN-1:15]);           // R8
            AST_ZEXT_HALF: assert (!(op_i == 5'd1 || op_i == 5'd17 ||
                (op_i >= 5'd23 && op_i <= 5'd26)) || result_o[XLEN-1:16] == '0); // R9
            AST_BIT_ONLY: assert (!(op_i == 5'd16 ||
                (op_i >= 5'd19 && op_i <= 5'd22)) || result_o[XLEN-1:1] == '0);  // R10
            AST_BYTE_ONLY: assert (!(op_i == 5'd6 || op_i == 5'd15) ||
                result_o[XLEN-1:8] == '0);                                     // R3
            AST_SZW_RANGE: assert (!(op_i >= 5'd3 && op_i <= 5'd5) ||
                (result_o[XLEN-1:35] == '0 && result_o[0] == 1'b0));           // R2
            AST_MASKOR_KEEP: assert (op_i != 5'd14 ||
                (result_o | src2_i) == result_o);                              // R7
        end
    end
endmodule

bind fz_alu fz_alu_chk #(.XLEN(XLEN)) u_chk (
    .src1_i    (src1_i),
    .src2_i    (src2_i),
    .op_i      (op_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/fz_alu_tb.sv
// Directed bench for fz_alu. Each scenario task drives its codes over the
// corner operands crossed with one another plus random pairs, and compares
// against a model written as the literal two-instruction sequence.
module fz_alu_tb;
    logic        clk = 1'b0;
    logic [63:0] src1, src2;
    logic [4:0]  op;
    logic [63:0] result;
    logic        illegal;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fz_alu u_dut (
        .src1_i    (src1),
        .src2_i    (src2),
        .op_i      (op),
        .result_o  (result),
        .illegal_o (illegal)
    );

    logic [63:0] corners [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                                 64'h7FFF_FFFF, 64'h8000_0000};

    function automatic logic [63:0] sxw(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] orcb(input logic [63:0] a);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = (a[i*8 +: 8] != 0) ? 8'hFF : 8'h00;
        return r;
    endfunction

    // Reference: each code expressed as the instruction pair it replaces.
    function automatic logic [63:0] model(input logic [4:0] c,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [31:0] t;
        logic [63:0] w;
        w = sxw(a[31:0] + b[31:0]);
        case (c)
            5'd0:  return (a << 32) >> 32;
            5'd1:  return (a << 48) >> 48;
            5'd2:  begin t = a[31:0] << 16; t = $signed(t) >>> 16; return sxw(t); end
            5'd3:  return (a << 32) >> 31;
            5'd4:  return (a << 32) >> 30;
            5'd5:  return (a << 32) >> 29;
            5'd6:  return (a >> 8) & 64'hFF;
            5'd7:  return (a << 4) + b;
            5'd8:  return (a >> 29) + b;
            5'd9:  return (a >> 30) + b;
            5'd10: return (a >> 31) + b;
            5'd11: return (a >> 32) + b;
            5'd12: return (a & 64'h1) + b;
            5'd13: return sxw(a[31:0] & 32'h1) + 64'h0 == 0 ? sxw(b[31:0]) :
                          sxw(b[31:0] + 32'h1);
            5'd14: return (a & 64'hFFFF_FFFF_FFFF_FF00) | b;
            5'd15: return w & 64'hFF;
            5'd16: return w & 64'h1;
            5'd17: return w & 64'hFFFF;
            5'd18: return {{48{w[15]}}, w[15:0]};
            5'd19: return (a & b) & 64'h1;
            5'd20: return (a | b) & 64'h1;
            5'd21: return (a ^ b) & 64'h1;
            5'd22: return orcb(a) & 64'h1;
            5'd23: return (a & b) & 64'hFFFF;
            5'd24: return (a | b) & 64'hFFFF;
            5'd25: return (a ^ b) & 64'hFFFF;
            5'd26: return orcb(a) & 64'hFFFF;
            default: return 64'h0;
        endcase
    endfunction

    task automatic apply_check(input logic [4:0] c, input logic [63:0] a,
                               input logic [63:0] b, input string req);
        logic [63:0] exp_r;
        logic        exp_f;
        @(posedge clk);
        #1;
        op = c; src1 = a; src2 = b;
        @(negedge clk);
        exp_r = model(c, a, b);
        exp_f = (c > 5'd26);
        total++;
        if (result !== exp_r || illegal !== exp_f) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h/%b expected=%h/%b",
                     req, c, a, b, result, illegal, exp_r, exp_f);
        end
    endtask

    task automatic sweep(input logic [4:0] c, input string req);
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                apply_check(c, corners[i], corners[j], req);
        for (int k = 0; k < 12; k++)
            apply_check(c, {$urandom, $urandom}, {$urandom, $urandom}, req);
    endtask

    task automatic test_extend;  // R1, src2 varied to show it is ignored
        for (int c = 0; c <= 2; c++) sweep(5'(c), "R1");
        apply_check(5'd2, 64'h0000_0000_0000_8001, 64'hFFFF, "R1");
    endtask
    task automatic test_szw;     // R2
        for (int c = 3; c <= 5; c++) sweep(5'(c), "R2");
    endtask
    task automatic test_byte;    // R3
        sweep(5'd6, "R3");
        apply_check(5'd6, 64'h1234_5678_9ABC_DEF0, 64'h0, "R3");
    endtask
    task automatic test_sl4add;  // R4
        sweep(5'd7, "R4");
    endtask
    task automatic test_sradd;   // R5
        for (int c = 8; c <= 11; c++) sweep(5'(c), "R5");
    endtask
    task automatic test_odd;     // R6, word carry into bit 31
        sweep(5'd12, "R6");
        sweep(5'd13, "R6");
        apply_check(5'd13, 64'h1, 64'h7FFF_FFFF, "R6");
    endtask
    task automatic test_maskor;  // R7
        sweep(5'd14, "R7");
    endtask
    task automatic test_wadd;    // R8, 32-bit wrap then narrow
        for (int c = 15; c <= 18; c++) sweep(5'(c), "R8");
        apply_check(5'd18, 64'h7FFF, 64'h1, "R8");
    endtask
    task automatic test_logic;   // R9
        for (int c = 19; c <= 21; c++) sweep(5'(c), "R9");
        for (int c = 23; c <= 25; c++) sweep(5'(c), "R9");
    endtask
    task automatic test_orcb;    // R10
        sweep(5'd22, "R10");
        sweep(5'd26, "R10");
        apply_check(5'd26, 64'h0000_0000_0000_0100, 64'h0, "R10");
    endtask
    task automatic test_illegal; // R11
        for (int c = 27; c <= 31; c++) sweep(5'(c), "R11");
    endtask

    initial begin
        op = 5'd31; src1 = '0; src2 = '0;
        apply_check(5'd0, 64'h0, 64'h0, "R1");
        test_extend();
        test_szw();
        test_byte();
        test_sl4add();
        test_sradd();
        test_odd();
        test_maskor();
        test_wadd();
        test_logic();
        test_orcb();
        test_illegal();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule